// File: doc/BRIEF.md
# Hall Sensor Interval Timer

This block times the gaps between commutation events from the three Hall sensors of a brushless motor. The sensor levels are synchronized to the system clock. Every change on an enabled sensor line becomes a single-cycle edge pulse. In two-phase mode only the U and V lines are watched, which gives four edges per electrical cycle. In three-phase mode U, V and W are all watched, which gives six. A counter runs on the system clock and restarts on every edge pulse. Its value at the moment of the edge is kept in a capture register, so the capture always holds the most recent edge-to-edge interval, which is a measure of rotor speed.

The block also keeps a rotation-direction flag by comparing each new sensor state with the one before it. It can raise a compare interrupt when the running count reaches a programmed value. It drives out a pulse train that toggles once for every programmed number of edge pulses.

Every pin is a plain level or strobe, so there is no valid/ready handshake and nothing can apply back-pressure. The capture value stays put until the next edge pulse replaces it, and a consumer may sample it at any time.

Top module: `hall_interval_timer`

## Requirements
- R1: In two-phase mode (`three_phase`=0), a change on `hall_u` or `hall_v` makes `edge_pulse` high for exactly one cycle. That cycle begins at the second rising clock edge after the change. A change on `hall_w` produces no pulse in this mode.
- R2: In three-phase mode (`three_phase`=1), a change on any of `hall_u`, `hall_v` or `hall_w` produces the same single-cycle `edge_pulse`. Several lines changing together produce one pulse.
- R3: While `run_en`=1, `count` rises by one on every clock. After a cycle with `edge_pulse` high, `count` is 0.
- R4: On each edge pulse, `capture` takes the `count` value of the pulse cycle. For edge pulses N cycles apart, `capture` therefore reads N-1.
- R5: With no edges, `count` wraps from all-ones (CNT_W bits, default 24) back to 0 and keeps counting.
- R6: A cycle with `sw_clr` high leaves `count` at 0 on the next cycle. If an edge pulse falls in the same cycle, `capture` still takes the pre-clear count.
- R7: `cmp_irq` is high for the cycle after a cycle in which `count` equals `cmp_val` while both `cmp_en` and `run_en` are 1. It never rises while `cmp_en`=0.
- R8: On an edge pulse, `dir_cw` becomes 1 if the new state is one forward step from the previous state and 0 if it is one step back. A non-adjacent or invalid jump leaves it unchanged. The forward order in two-phase mode, as {V,U}, is 00, 01, 11, 10. In three-phase mode, as {W,V,U}, it is 001, 011, 010, 110, 100, 101. The states 000 and 111 are invalid in three-phase mode.
- R9: While `run_en`=0, `count`, `capture`, `dir_cw`, `pulse_out` and the divider are held at 0, and no `edge_pulse` or `cmp_irq` appears. Re-enabling produces no spurious edge pulse.
- R10: `pulse_out` toggles on every (`div_factor`+1)-th edge pulse, so its period spans 2·(`div_factor`+1) edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low holds the block idle |
| three_phase | input | 1 | 1 watches U, V, W; 0 watches U, V only |
| cmp_en | input | 1 | Compare interrupt enable |
| cmp_val | input | CNT_W | Compare value |
| sw_clr | input | 1 | Counter clear strobe |
| div_factor | input | DIV_W | Edge pulses per output toggle, minus one |
| hall_u | input | 1 | Hall sensor U (asynchronous) |
| hall_v | input | 1 | Hall sensor V (asynchronous) |
| hall_w | input | 1 | Hall sensor W (asynchronous) |
| edge_pulse | output | 1 | One-cycle strobe per decoded sensor edge |
| dir_cw | output | 1 | 1 clockwise, 0 counter-clockwise |
| count | output | CNT_W | Running interval counter |
| capture | output | CNT_W | Last edge-to-edge interval |
| cmp_irq | output | 1 | Compare interrupt pulse |
| pulse_out | output | 1 | Divided, toggling edge pulse output |

## Verification
The main path is driven with forward sensor sequences, backward sequences and mixed sequences, in both modes, with random gaps between steps. Forward runs against backward runs tell apart a correct direction decode from a flag stuck at one value. Toggling W in two-phase mode separates proper channel masking from a decoder that always watches all three lines. Fixed-gap steps, a clear aligned with an edge pulse, and a long gap with no edges separate the capture, clear-priority and wrap behaviours. Random drops of the enable and random mode switches check that no spurious edges or stale state survive them.

// File: rtl/hit_pkg.sv
package hit_pkg;

  // Sensor bundle, bit order {w, v, u}
  typedef logic [2:0] hall_t;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_REV  = 2'd2
  } step_e;

  localparam logic [2:0] POS_BAD = 3'd7;

  // Position of a sensor state along the forward rotation order
  function automatic logic [2:0] seq_pos(input hall_t h, input logic three);
    logic [2:0] p;
    if (three) begin
      case (h)
        3'b001:  p = 3'd0;
        3'b011:  p = 3'd1;
        3'b010:  p = 3'd2;
        3'b110:  p = 3'd3;
        3'b100:  p = 3'd4;
        3'b101:  p = 3'd5;
        default: p = POS_BAD;
      endcase
    end else begin
      case (h[1:0])
        2'b00:   p = 3'd0;
        2'b01:   p = 3'd1;
        2'b11:   p = 3'd2;
        default: p = 3'd3;
      endcase
    end
    return p;
  endfunction

  function automatic step_e classify(input hall_t prev, input hall_t cur, input logic three);
    logic [2:0] pp, cp, last, pn, cn;
    step_e r;
    pp   = seq_pos(prev, three);
    cp   = seq_pos(cur, three);
    last = three ? 3'd5 : 3'd3;
    pn   = (pp == last) ? 3'd0 : pp + 3'd1;
    cn   = (cp == last) ? 3'd0 : cp + 3'd1;
    if (pp == POS_BAD || cp == POS_BAD) r = STEP_NONE;
    else if (cp == pn)                  r = STEP_FWD;
    else if (pp == cn)                  r = STEP_REV;
    else                                r = STEP_NONE;
    return r;
  endfunction

endpackage

// File: rtl/hit_hall_front.sv
module hit_hall_front
  import hit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  logic  three_phase,
  input  hall_t hall_i,
  output logic  edge_o,
  output logic  dir_cw_o
);

  localparam int LAST = SYNC_STAGES - 1;

  hall_t stage_q [SYNC_STAGES];
  hall_t prev_q;
  hall_t cur;
  hall_t mask;
  logic  dir_q;
  step_e step;

  genvar g;
  for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= hall_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign cur  = stage_q[LAST];
  assign mask = three_phase ? 3'b111 : 3'b011;

  // prev tracks always, so re-enabling never sees a stale difference
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign edge_o = run_en && (((cur ^ prev_q) & mask) != 3'b000);
  assign step   = classify(prev_q, cur, three_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_q <= 1'b0;
    else if (!run_en) dir_q <= 1'b0;
    else if (edge_o) begin
      case (step)
        STEP_FWD: dir_q <= 1'b1;
        STEP_REV: dir_q <= 1'b0;
        default:  dir_q <= dir_q;
      endcase
    end
  end

  assign dir_cw_o = dir_q;

  assert_dir_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !dir_cw_o);

  assert_dir_moves_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !edge_o) |=> $stable(dir_cw_o));

endmodule

// File: rtl/hit_interval_ctr.sv
module hit_interval_ctr #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             edge_i,
  input  logic             sw_clr,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             irq_q;
  logic             hit;

  assign hit = run_en && cmp_en && (cnt_q == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (!run_en) begin
        cnt_q <= '0;
        cap_q <= '0;
      end else begin
        if (edge_i) cap_q <= cnt_q;
        if (edge_i || sw_clr) cnt_q <= '0;
        else                  cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign count_o   = cnt_q;
  assign capture_o = cap_q;
  assign irq_o     = irq_q;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !edge_i && !sw_clr) |=> (count_o == $past(count_o) + ONE));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (edge_i || sw_clr)) |=> (count_o == '0));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && edge_i) |=> (capture_o == $past(count_o)));

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (count_o == '0 && capture_o == '0));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cmp_en && run_en));

endmodule

// File: rtl/hit_pulse_div.sv
module hit_pulse_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             edge_i,
  input  logic [DIV_W-1:0] factor,
  output logic             pulse_o
);

  logic [DIV_W-1:0] dcnt_q;
  logic             tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      tog_q  <= 1'b0;
    end else if (!run_en) begin
      dcnt_q <= '0;
      tog_q  <= 1'b0;
    end else if (edge_i) begin
      if (dcnt_q >= factor) begin
        dcnt_q <= '0;
        tog_q  <= ~tog_q;
      end else begin
        dcnt_q <= dcnt_q + DIV_W'(1);
      end
    end
  end

  assign pulse_o = tog_q;

  assert_toggle_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_o) |-> ($past(edge_i) || !$past(run_en)));

endmodule

// File: rtl/hall_interval_timer.sv
module hall_interval_timer
  import hit_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             three_phase,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             sw_clr,
  input  logic [DIV_W-1:0] div_factor,
  input  logic             hall_u,
  input  logic             hall_v,
  input  logic             hall_w,
  output logic             edge_pulse,
  output logic             dir_cw,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             cmp_irq,
  output logic             pulse_out
);

  hall_t hall_bus;
  logic  edge_s;

  assign hall_bus = {hall_w, hall_v, hall_u};

  hit_hall_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .three_phase(three_phase),
    .hall_i     (hall_bus),
    .edge_o     (edge_s),
    .dir_cw_o   (dir_cw)
  );

  hit_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .edge_i   (edge_s),
    .sw_clr   (sw_clr),
    .cmp_en   (cmp_en),
    .cmp_val  (cmp_val),
    .count_o  (count),
    .capture_o(capture),
    .irq_o    (cmp_irq)
  );

  hit_pulse_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .edge_i (edge_s),
    .factor (div_factor),
    .pulse_o(pulse_out)
  );

  assign edge_pulse = edge_s;

  assert_no_idle_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !cmp_irq);

endmodule

// File: tb/sim_hall_interval_timer.sv
module sim_hall_interval_timer;

  localparam int CW = 12;
  localparam int DW = 8;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, three_phase = 1'b0, cmp_en = 1'b0, sw_clr = 1'b0;
  logic [CW-1:0] cmp_val = '0;
  logic [DW-1:0] div_factor = '0;
  logic hall_u = 1'b0, hall_v = 1'b0, hall_w = 1'b0;
  logic edge_pulse, dir_cw, cmp_irq, pulse_out;
  logic [CW-1:0] count, capture;

  int n_checks = 0, n_errors = 0;
  bit model_on = 0, done = 0;
  int edge_seen = 0, irq_seen = 0;
  int pos = 0;

  always #(TCK/2) clk = ~clk;

  hall_interval_timer #(.CNT_W(CW), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .three_phase(three_phase),
    .cmp_en(cmp_en), .cmp_val(cmp_val), .sw_clr(sw_clr), .div_factor(div_factor),
    .hall_u(hall_u), .hall_v(hall_v), .hall_w(hall_w),
    .edge_pulse(edge_pulse), .dir_cw(dir_cw), .count(count), .capture(capture),
    .cmp_irq(cmp_irq), .pulse_out(pulse_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Forward sequences from the requirements (R8)
  function automatic logic [2:0] seq3(input int i);
    logic [2:0] t [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    return t[i];
  endfunction
  function automatic logic [1:0] seq2(input int i);
    logic [1:0] t [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    return t[i];
  endfunction
  function automatic int find_pos(input logic [2:0] h, input logic three);
    if (three) begin
      for (int i = 0; i < 6; i++) if (seq3(i) == h) return i;
      return -1;
    end
    for (int i = 0; i < 4; i++) if (seq2(i) == h[1:0]) return i;
    return -1;
  endfunction

  // Reference model, from the requirements
  logic [2:0] m_s1, m_s2, m_prev;
  logic [CW-1:0] m_cnt, m_cap;
  logic [DW-1:0] m_dcnt;
  logic m_dir, m_irq, m_tog, m_edge;
  logic [2:0] m_mask;
  assign m_mask = three_phase ? 3'b111 : 3'b011;
  assign m_edge = run_en && (((m_s2 ^ m_prev) & m_mask) != 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_cnt <= 0; m_cap <= 0;
      m_dcnt <= 0; m_dir <= 0; m_irq <= 0; m_tog <= 0;
    end else begin
      m_s1 <= {hall_w, hall_v, hall_u};
      m_s2 <= m_s1;
      m_prev <= m_s2;
      m_irq <= run_en && cmp_en && (m_cnt == cmp_val);
      if (!run_en) begin
        m_cnt <= 0; m_cap <= 0; m_dcnt <= 0; m_tog <= 0; m_dir <= 0;
      end else begin
        if (m_edge) m_cap <= m_cnt;
        m_cnt <= (m_edge || sw_clr) ? '0 : m_cnt + 1'b1;
        if (m_edge) begin
          int pp, cp, n;
          n  = three_phase ? 6 : 4;
          pp = find_pos(m_prev, three_phase);
          cp = find_pos(m_s2, three_phase);
          if (pp >= 0 && cp >= 0) begin
            if (cp == (pp + 1) % n) m_dir <= 1'b1;
            else if (pp == (cp + 1) % n) m_dir <= 1'b0;
          end
          if (m_dcnt >= div_factor) begin m_dcnt <= 0; m_tog <= ~m_tog; end
          else m_dcnt <= m_dcnt + 1'b1;
        end
      end
    end
  end

  // Sample a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(TCK/4);
    if (edge_pulse) edge_seen++;
    if (cmp_irq) irq_seen++;
    if (model_on) begin
      chk(three_phase ? "R2 edge" : "R1 edge", edge_pulse, m_edge);
      chk("R8 dir", dir_cw, m_dir);
      chk("R3 count", count, m_cnt);
      chk("R4 capture", capture, m_cap);
      chk("R7 irq", cmp_irq, m_irq);
      chk("R10 pulse", pulse_out, m_tog);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic drive_pos();
    if (three_phase) {hall_w, hall_v, hall_u} = seq3(pos);
    else {hall_v, hall_u} = seq2(pos);
  endtask
  task automatic step(input bit fwd);
    int n;
    n = three_phase ? 6 : 4;
    pos = fwd ? (pos + 1) % n : (pos + n - 1) % n;
    drive_pos();
  endtask
  task automatic set_mode(input bit three);
    three_phase = three;
    pos = pos % (three ? 6 : 4);
    drive_pos();
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int e0, c0, i0;
    void'($urandom(32'd5150));
    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R9 reset / idle state
    chk("R9 reset count", count, 0);
    chk("R9 reset capture", capture, 0);
    chk("R9 reset dir", dir_cw, 0);
    chk("R9 reset pulse", pulse_out, 0);
    model_on = 1;

    // R9 idle: sensor edges while disabled give nothing
    e0 = edge_seen;
    step(1); tick(5);
    chk("R9 no edge when idle", edge_seen, e0);

    run_en = 1'b1; tick(3);
    chk("R9 no spurious edge on enable", edge_seen, e0);

    // R3 counting
    c0 = count; tick(1);
    chk("R3 increments", count, c0 + 1);

    // R4 interval: steps 20 cycles apart
    step(1); tick(20); step(1); tick(4);
    chk("R4 capture interval", capture, 19);

    // R1 W ignored in two-phase mode
    e0 = edge_seen;
    hall_w = ~hall_w; tick(5);
    chk("R1 W ignored", edge_seen, e0);

    // R8 forward then reverse
    step(1); tick(4); step(1); tick(4);
    chk("R8 forward", dir_cw, 1);
    step(0); tick(4);
    chk("R8 reverse", dir_cw, 0);

    // R2 W counts in three-phase mode
    set_mode(1'b1); tick(5);
    e0 = edge_seen;
    step(1); tick(4);
    chk("R2 three-phase edge", edge_seen, e0 + 1);

    // R6 clear coinciding with an edge pulse
    tick(10);
    step(1);
    tick(2);
    chk("R6 edge present", edge_pulse, 1);
    c0 = count;
    sw_clr = 1'b1;
    tick(1);
    sw_clr = 1'b0;
    chk("R6 capture pre-clear", capture, c0);
    chk("R6 count cleared", count, 0);

    // R7 compare
    cmp_val = 12'd10; cmp_en = 1'b1;
    sw_clr = 1'b1; tick(1); sw_clr = 1'b0;
    i0 = irq_seen; tick(30);
    chk("R7 one irq", irq_seen, i0 + 1);
    cmp_en = 1'b0;
    sw_clr = 1'b1; tick(1); sw_clr = 1'b0;
    i0 = irq_seen; tick(30);
    chk("R7 no irq when disabled", irq_seen, i0);

    // R5 wrap
    sw_clr = 1'b1; tick(1); sw_clr = 1'b0;
    chk("R5 start", count, 0);
    tick((1 << CW) - 1);
    chk("R5 all ones", count, (1 << CW) - 1);
    tick(1);
    chk("R5 wrapped", count, 0);

    // R10 divider
    run_en = 1'b0; div_factor = 8'd2; tick(2);
    chk("R9 pulse idle", pulse_out, 0);
    run_en = 1'b1; tick(2);
    for (int k = 0; k < 3; k++) begin step(1); tick(6); end
    chk("R10 toggled after 3", pulse_out, 1);
    for (int k = 0; k < 3; k++) begin step(1); tick(6); end
    chk("R10 back after 6", pulse_out, 0);

    // R9 run drop clears state
    run_en = 1'b0; tick(2);
    chk("R9 count idle", count, 0);
    chk("R9 capture idle", capture, 0);
    chk("R9 dir idle", dir_cw, 0);
    run_en = 1'b1;

    // Constrained random phase
    for (int cyc = 0; cyc < 8000; cyc++) begin
      tick(1);
      sw_clr = ($urandom % 200) == 0;
      if (($urandom % 10) == 0) step(($urandom % 10) < 7);
      if (($urandom % 60) == 0) hall_w = three_phase ? hall_w : ~hall_w;
      if (($urandom % 600) == 0) run_en = ~run_en;
      if (($urandom % 900) == 0) set_mode(~three_phase);
      if (($urandom % 300) == 0) begin
        cmp_val = CW'($urandom % 64);
        cmp_en = $urandom % 2;
      end
      if (($urandom % 400) == 0) div_factor = DW'($urandom % 4);
    end

    tick(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule